// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects an A port and a B port through a number of independent lanes (two lanes of eight bits by default). In each lane, data can flow from A to B or from B to A. The forwarded value is either the live value on the opposite port or a copy captured earlier. Each lane holds two capture registers. One takes its value from the A port and the other from the B port. Each register has its own capture strobe.

Each lane has four controls:
- An isolate control. When it is high, the lane drives neither port.
- A direction control. It picks which single port the lane drives.
- Two source selects, one for each direction. Each one chooses between the live value and the held value.

Capture runs whatever the output controls are set to. A lane can therefore snapshot either bus, or both, while it is isolated.

Each port is split into three signals: an input value, an output value and a per-bit drive enable. An external tri-state buffer or a bench can resolve the bus from these. A single system clock samples the capture strobes. A held value is loaded on the clock edge where the strobe is seen rising. The live path is combinational.

Top module: `regbus_xcvr`

## Requirements
- R1: While a lane's `lane_off` bit is 1, both of that lane's drive-enable slices (`a_drv`, `b_drv`) are all zero, whatever the direction and select inputs are.
- R2: With `lane_off`=0 and `dir_to_b`=0, the lane's `a_drv` slice is all ones and its `b_drv` slice is zero. With `b2a_use_held`=0, the lane's `a_out` slice equals its `b_in` slice combinationally, with no clock edge needed.
- R3: With `lane_off`=0, `dir_to_b`=0 and `b2a_use_held`=1, the lane's `a_out` slice shows the lane's held B-side value.
- R4: With `lane_off`=0 and `dir_to_b`=1, the lane's `b_drv` slice is all ones and its `a_drv` slice is zero. With `a2b_use_held`=0, the lane's `b_out` slice equals its `a_in` slice combinationally.
- R5: With `lane_off`=0, `dir_to_b`=1 and `a2b_use_held`=1, the lane's `b_out` slice shows the lane's held A-side value.
- R6: A held value loads on a `clk` rising edge where the lane's capture strobe is 1 and was 0 at the previous edge. It takes the port input present at that edge and is visible right after that edge. A strobe held at 1 captures only once.
- R7: Capture works the same while the lane is isolated or driving either port.
- R8: Lanes are independent. The controls, strobes and data of one lane never change another lane's held values or outputs.
- R9: While `rst` is 1 at a `clk` edge, all held values clear to zero and each strobe's history is set to 1. A strobe that stays high through the release of reset therefore causes no capture.
- R10: Any output bit whose drive enable is 0 reads 0.
- R11: A lane never enables drive on both ports at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples capture strobes |
| rst | input | 1 | Synchronous active-high reset |
| lane_off | input | NLANES | Per-lane isolate; 1 = drive neither port |
| dir_to_b | input | NLANES | Per-lane direction; 1 = drive B, 0 = drive A |
| a2b_use_held | input | NLANES | B-side source: 1 = held A value, 0 = live A |
| b2a_use_held | input | NLANES | A-side source: 1 = held B value, 0 = live B |
| cap_a | input | NLANES | Per-lane strobe capturing the A port |
| cap_b | input | NLANES | Per-lane strobe capturing the B port |
| a_in | input | NLANES*LANE_W | Value present on the A port |
| b_in | input | NLANES*LANE_W | Value present on the B port |
| a_out | output | NLANES*LANE_W | Value the block drives onto the A port |
| a_drv | output | NLANES*LANE_W | Per-bit drive enable for the A port |
| b_out | output | NLANES*LANE_W | Value the block drives onto the B port |
| b_drv | output | NLANES*LANE_W | Per-bit drive enable for the B port |

## Verification
The hardest case to reach from the ports is a strobe that is already high when reset is released. It must not capture. To reach it, the stimulus holds the A strobes high through the whole reset. It then selects the held path right away and expects zero. Only after that does it lower a strobe and raise it again with new data.

A second hard case is a capture made while the lane is isolated. The value cannot be seen until the lane is enabled on the held path. The stimulus therefore captures first, checks that the lane stays quiet, and only then enables the lane. A long random phase then compares every lane against a behavioural model on every clock.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    PATH_ISOLATE  = 2'd0,
    PATH_TOWARD_A = 2'd1,
    PATH_TOWARD_B = 2'd2
  } path_e;

  // Isolate wins over direction; direction then names the single driven port.
  function automatic path_e pick_path(input logic off, input logic to_b);
    if (off)  return PATH_ISOLATE;
    if (to_b) return PATH_TOWARD_B;
    return PATH_TOWARD_A;
  endfunction

endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic [W-1:0] din,
  output logic [W-1:0] held
);

  logic strobe_q;
  logic take;

  assign take = strobe & ~strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b1;
      held     <= '0;
    end else begin
      strobe_q <= strobe;
      if (take) held <= din;
    end
  end

endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  path_e        path,
  input  logic         a2b_held_sel,
  input  logic         b2a_held_sel,
  input  logic [W-1:0] a_live,
  input  logic [W-1:0] b_live,
  input  logic [W-1:0] a_held,
  input  logic [W-1:0] b_held,
  output logic [W-1:0] a_val,
  output logic [W-1:0] a_en,
  output logic [W-1:0] b_val,
  output logic [W-1:0] b_en
);

  always_comb begin
    a_val = '0;
    a_en  = '0;
    b_val = '0;
    b_en  = '0;
    case (path)
      PATH_TOWARD_A: begin
        a_en  = '1;
        a_val = b2a_held_sel ? b_held : b_live;
      end
      PATH_TOWARD_B: begin
        b_en  = '1;
        b_val = a2b_held_sel ? a_held : a_live;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         off,
  input  logic         to_b,
  input  logic         a2b_held_sel,
  input  logic         b2a_held_sel,
  input  logic         strobe_a,
  input  logic         strobe_b,
  input  logic [W-1:0] a_live,
  input  logic [W-1:0] b_live,
  output logic [W-1:0] a_val,
  output logic [W-1:0] a_en,
  output logic [W-1:0] b_val,
  output logic [W-1:0] b_en
);

  logic [W-1:0] held_from_a;
  logic [W-1:0] held_from_b;
  path_e        path;

  assign path = pick_path(off, to_b);

  xcvr_capture #(.W(W)) i_cap_a (
    .clk(clk), .rst(rst), .strobe(strobe_a), .din(a_live), .held(held_from_a)
  );

  xcvr_capture #(.W(W)) i_cap_b (
    .clk(clk), .rst(rst), .strobe(strobe_b), .din(b_live), .held(held_from_b)
  );

  xcvr_route #(.W(W)) i_route (
    .path(path),
    .a2b_held_sel(a2b_held_sel),
    .b2a_held_sel(b2a_held_sel),
    .a_live(a_live),
    .b_live(b_live),
    .a_held(held_from_a),
    .b_held(held_from_b),
    .a_val(a_val),
    .a_en(a_en),
    .b_val(b_val),
    .b_en(b_en)
  );

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int NLANES = 2,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NLANES-1:0]        lane_off,
  input  logic [NLANES-1:0]        dir_to_b,
  input  logic [NLANES-1:0]        a2b_use_held,
  input  logic [NLANES-1:0]        b2a_use_held,
  input  logic [NLANES-1:0]        cap_a,
  input  logic [NLANES-1:0]        cap_b,
  input  logic [NLANES*LANE_W-1:0] a_in,
  input  logic [NLANES*LANE_W-1:0] b_in,
  output logic [NLANES*LANE_W-1:0] a_out,
  output logic [NLANES*LANE_W-1:0] a_drv,
  output logic [NLANES*LANE_W-1:0] b_out,
  output logic [NLANES*LANE_W-1:0] b_drv
);

  localparam int BUS_W = NLANES * LANE_W;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    localparam int LO = g * LANE_W;
    xcvr_lane #(.W(LANE_W)) i_lane (
      .clk         (clk),
      .rst         (rst),
      .off         (lane_off[g]),
      .to_b        (dir_to_b[g]),
      .a2b_held_sel(a2b_use_held[g]),
      .b2a_held_sel(b2a_use_held[g]),
      .strobe_a    (cap_a[g]),
      .strobe_b    (cap_b[g]),
      .a_live      (a_in[LO +: LANE_W]),
      .b_live      (b_in[LO +: LANE_W]),
      .a_val       (a_out[LO +: LANE_W]),
      .a_en        (a_drv[LO +: LANE_W]),
      .b_val       (b_out[LO +: LANE_W]),
      .b_en        (b_drv[LO +: LANE_W])
    );
  end

  if (BUS_W < 1) begin : g_bad_size
    $error("regbus_xcvr: empty bus");
  end

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int NLANES = 2,
  parameter int LANE_W = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NLANES-1:0]        lane_off,
  input logic [NLANES-1:0]        dir_to_b,
  input logic [NLANES-1:0]        a2b_use_held,
  input logic [NLANES-1:0]        b2a_use_held,
  input logic [NLANES-1:0]        cap_a,
  input logic [NLANES-1:0]        cap_b,
  input logic [NLANES*LANE_W-1:0] a_in,
  input logic [NLANES*LANE_W-1:0] b_in,
  input logic [NLANES*LANE_W-1:0] a_out,
  input logic [NLANES*LANE_W-1:0] a_drv,
  input logic [NLANES*LANE_W-1:0] b_out,
  input logic [NLANES*LANE_W-1:0] b_drv
);

  AST_NEVER_BOTH_SIDES: assert property (@(posedge clk) disable iff (rst)
    (a_drv & b_drv) == '0); // R11

  AST_UNDRIVEN_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((a_out & ~a_drv) == '0) && ((b_out & ~b_drv) == '0)); // R10

  for (genvar g = 0; g < NLANES; g++) begin : g_chk
    localparam int LO = g * LANE_W;

    AST_OFF_IS_QUIET: assert property (@(posedge clk) disable iff (rst)
      lane_off[g] |-> (a_drv[LO +: LANE_W] == '0) && (b_drv[LO +: LANE_W] == '0)); // R1

    AST_LIVE_TOWARD_A: assert property (@(posedge clk) disable iff (rst)
      (!lane_off[g] && !dir_to_b[g] && !b2a_use_held[g])
        |-> (a_out[LO +: LANE_W] == b_in[LO +: LANE_W])); // R2

    AST_LIVE_TOWARD_B: assert property (@(posedge clk) disable iff (rst)
      (!lane_off[g] && dir_to_b[g] && !a2b_use_held[g])
        |-> (b_out[LO +: LANE_W] == a_in[LO +: LANE_W])); // R4

    AST_HELD_A_STEADY: assert property (@(posedge clk) disable iff (rst)
      (!lane_off[g] && dir_to_b[g] && a2b_use_held[g] && !$past(rst)
        && $past(!lane_off[g] && dir_to_b[g] && a2b_use_held[g]) && !$past(cap_a[g]))
        |-> $stable(b_out[LO +: LANE_W])); // R6

    AST_HELD_B_STEADY: assert property (@(posedge clk) disable iff (rst)
      (!lane_off[g] && !dir_to_b[g] && b2a_use_held[g] && !$past(rst)
        && $past(!lane_off[g] && !dir_to_b[g] && b2a_use_held[g]) && !$past(cap_b[g]))
        |-> $stable(a_out[LO +: LANE_W])); // R6
  end

endmodule

bind regbus_xcvr xcvr_checker #(.NLANES(NLANES), .LANE_W(LANE_W)) i_xcvr_checker (
  .clk(clk), .rst(rst), .lane_off(lane_off), .dir_to_b(dir_to_b),
  .a2b_use_held(a2b_use_held), .b2a_use_held(b2a_use_held),
  .cap_a(cap_a), .cap_b(cap_b), .a_in(a_in), .b_in(b_in),
  .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv)
);

// File: tb/test_regbus_xcvr.sv
module test_regbus_xcvr;

  localparam int NL = 2;
  localparam int W  = 8;
  localparam int BW = NL * W;

  logic          clk = 1'b0;
  logic          rst;
  logic [NL-1:0] lane_off, dir_to_b, a2b_use_held, b2a_use_held, cap_a, cap_b;
  logic [BW-1:0] a_in, b_in;
  logic [BW-1:0] a_out, a_drv, b_out, b_drv;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  regbus_xcvr #(.NLANES(NL), .LANE_W(W)) i_regbus_xcvr (
    .clk(clk), .rst(rst), .lane_off(lane_off), .dir_to_b(dir_to_b),
    .a2b_use_held(a2b_use_held), .b2a_use_held(b2a_use_held),
    .cap_a(cap_a), .cap_b(cap_b), .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv)
  );

  // Behavioural reference: held values and strobe history per lane.
  logic [W-1:0] m_ha [NL];
  logic [W-1:0] m_hb [NL];
  bit           m_pa [NL];
  bit           m_pb [NL];

  always @(posedge clk) begin
    for (int l = 0; l < NL; l++) begin
      if (rst) begin
        m_ha[l] <= '0; m_hb[l] <= '0; m_pa[l] <= 1'b1; m_pb[l] <= 1'b1;
      end else begin
        m_pa[l] <= cap_a[l];
        m_pb[l] <= cap_b[l];
        if (cap_a[l] && !m_pa[l]) m_ha[l] <= a_in[l*W +: W];
        if (cap_b[l] && !m_pb[l]) m_hb[l] <= b_in[l*W +: W];
      end
    end
  end

  task automatic compare_model();
    for (int l = 0; l < NL; l++) begin
      logic [W-1:0] ea, eae, eb, ebe;
      string tag;
      ea = '0; eae = '0; eb = '0; ebe = '0;
      if (lane_off[l]) tag = "R1";
      else if (!dir_to_b[l]) begin
        eae = '1;
        ea  = b2a_use_held[l] ? m_hb[l] : b_in[l*W +: W];
        tag = b2a_use_held[l] ? "R3" : "R2";
      end else begin
        ebe = '1;
        eb  = a2b_use_held[l] ? m_ha[l] : a_in[l*W +: W];
        tag = a2b_use_held[l] ? "R5" : "R4";
      end
      checks++;
      if ({a_out[l*W +: W], a_drv[l*W +: W], b_out[l*W +: W], b_drv[l*W +: W]} !== {ea, eae, eb, ebe}) begin
        fails++;
        $display("FAIL %s lane %0d: actual a=%h/%h b=%h/%h expected a=%h/%h b=%h/%h", tag, l,
                 a_out[l*W +: W], a_drv[l*W +: W], b_out[l*W +: W], b_drv[l*W +: W], ea, eae, eb, ebe);
      end
    end
  endtask

  task automatic check8(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Advance one clock and sample well after the edge.
  task automatic tick();
    @(posedge clk);
    #3;
    compare_model();
  endtask

  initial begin
    rst = 1'b1; lane_off = '1; dir_to_b = '0; a2b_use_held = '0; b2a_use_held = '0;
    cap_a = '1; cap_b = '0; a_in = 16'hA5A5; b_in = 16'h0F0F;
    repeat (4) tick();
    check8("R1 reset lane0 a_drv", a_drv[7:0], 8'h00);
    check8("R1 reset lane1 b_drv", b_drv[15:8], 8'h00);
    rst = 1'b0;
    tick();
    // R9: strobe high through reset must not capture; held value is zero
    lane_off = 2'b00; dir_to_b = 2'b11; a2b_use_held = 2'b11;
    tick();
    check8("R9 no capture from held strobe", b_out[7:0], 8'h00);
    check8("R5 b_drv on", b_drv[7:0], 8'hFF);
    check8("R11 a_drv off", a_drv[7:0], 8'h00);
    cap_a = 2'b00;
    tick();
    cap_a[0] = 1'b1; a_in[7:0] = 8'h3C;
    tick();
    check8("R6 capture on rise", b_out[7:0], 8'h3C);
    a_in[7:0] = 8'h77;
    tick(); tick();
    check8("R6 held strobe no recapture", b_out[7:0], 8'h3C);
    // R7: capture while isolated
    lane_off[1] = 1'b1; a_in[15:8] = 8'h5A; cap_a[1] = 1'b1;
    tick();
    check8("R1 isolated b_drv", b_drv[15:8], 8'h00);
    check8("R10 isolated b_out", b_out[15:8], 8'h00);
    lane_off[1] = 1'b0; a_in[15:8] = 8'h11;
    tick();
    check8("R7 capture while isolated", b_out[15:8], 8'h5A);
    check8("R8 other lane untouched", b_out[7:0], 8'h3C);
    // Toward A, live then held
    dir_to_b[0] = 1'b0; b2a_use_held[0] = 1'b0; b_in[7:0] = 8'hC3;
    #1;
    check8("R2 live B to A", a_out[7:0], 8'hC3);
    check8("R11 b_drv off", b_drv[7:0], 8'h00);
    b2a_use_held[0] = 1'b1;
    tick();
    check8("R3 held B empty", a_out[7:0], 8'h00);
    cap_b[0] = 1'b1; b_in[7:0] = 8'hE1;
    tick();
    cap_b[0] = 1'b0; b_in[7:0] = 8'h00;
    tick();
    check8("R3 held B after capture", a_out[7:0], 8'hE1);
    a2b_use_held[1] = 1'b0; a_in[15:8] = 8'h99;
    #1;
    check8("R4 live A to B", b_out[15:8], 8'h99);
    check8("R8 lane0 still held", a_out[7:0], 8'hE1);
    // Random phase against the model
    for (int n = 0; n < 3000; n++) begin
      lane_off     = NL'($urandom);
      dir_to_b     = NL'($urandom);
      a2b_use_held = NL'($urandom);
      b2a_use_held = NL'($urandom);
      cap_a        = NL'($urandom);
      cap_b        = NL'($urandom);
      a_in         = BW'($urandom);
      b_in         = BW'($urandom);
      tick();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule